// File: doc/BRIEF.md
# Major/Minor Road Crossing Light Sequencer

This block drives the lamps at a junction where a busy major road crosses a quiet minor road. The major road shows green until a sensor reports a car waiting on the minor road. The block then steps through a fixed ring of five phases: major warning, minor go, minor warning, major hold, and back to major go. An internal down-counter times each phase. It has two lengths, short and long, both given in clock cycles. The minor-road go phase ends early when a second sensor reports that the waiting car has crossed. The major hold phase always runs its full long time, so the major road keeps a minimum green before a new minor request can be served.

Both warning phases show red together with yellow on the road that is about to get green. The road that is losing green shows plain yellow. Each road gets a 3-bit lamp vector. The vectors come straight from flops, so they change only on a clock edge.

Top module: `tlc_crossing`

## Requirements
- R1: After reset and until the first car request, major_lamp = 3'b001 (green) and minor_lamp = 3'b100 (red). Lamp bit order is {red, yellow, green}.
- R2: In major go (major 001, minor 100) the block stays put for any number of cycles while car_present is low. A car_present high during a major-go cycle moves the block to major warning at the next clock edge.
- R3: Major warning shows major 3'b010 and minor 3'b110, and lasts exactly SHORT_CYCLES cycles.
- R4: Minor go shows major 3'b100 and minor 3'b001, and lasts exactly LONG_CYCLES cycles if car_passed stays low.
- R5: A car_passed high in cycle k (counting from 0) of minor go ends minor go at the next edge, so minor go lasts k+1 cycles. The minor warning that follows still lasts the full SHORT_CYCLES: no earlier count carries over.
- R6: Minor warning shows major 3'b110 and minor 3'b010, and lasts exactly SHORT_CYCLES cycles.
- R7: Major hold shows major 3'b001 and minor 3'b100, and lasts exactly LONG_CYCLES cycles whatever the sensors do. The block then returns to major go.
- R8: car_present has no effect outside major go, and car_passed has no effect outside minor go. Phase lengths are unchanged by either.
- R9: In every cycle at least one road shows red, and the two roads never show green in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| car_present | input | 1 | Minor-road car waiting, one-cycle pulse or level |
| car_passed | input | 1 | Minor-road car has crossed |
| major_lamp | output | 3 | Major road lamps {red, yellow, green} |
| minor_lamp | output | 3 | Minor road lamps {red, yellow, green} |

## Verification
Two events can fall in the same cycle in minor go: a car_passed pulse and the timer expiry. The most delicate case is a pass in the last long cycle, which coincides with the timeout. Less directly, an early pass must also not leave a pending expiry that would shorten the next short phase. The bench sweeps the pass offset over every cycle of minor go, including the last one, and over the no-pass case. In each run it measures the length of every phase cycle by cycle and compares it with SHORT_CYCLES, LONG_CYCLES or k+1. Sensor pulses injected in the other phases must leave all phase lengths unchanged.

// File: rtl/tlc_pkg.sv
package tlc_pkg;

  typedef enum logic [2:0] {
    PH_MAJ_GO   = 3'd0,
    PH_MAJ_WARN = 3'd1,
    PH_MIN_GO   = 3'd2,
    PH_MIN_WARN = 3'd3,
    PH_MAJ_HOLD = 3'd4
  } phase_t;

  // lamp vector bit order: {red, yellow, green}
  localparam logic [2:0] LAMP_GRN = 3'b001;
  localparam logic [2:0] LAMP_YEL = 3'b010;
  localparam logic [2:0] LAMP_RED = 3'b100;
  localparam logic [2:0] LAMP_RY  = 3'b110;

  typedef struct packed {
    logic [2:0] major;
    logic [2:0] minor;
  } lamp_pair_t;

  function automatic lamp_pair_t phase_lamps(phase_t ph);
    lamp_pair_t lp;
    case (ph)
      PH_MAJ_WARN: begin lp.major = LAMP_YEL; lp.minor = LAMP_RY;  end
      PH_MIN_GO:   begin lp.major = LAMP_RED; lp.minor = LAMP_GRN; end
      PH_MIN_WARN: begin lp.major = LAMP_RY;  lp.minor = LAMP_YEL; end
      default:     begin lp.major = LAMP_GRN; lp.minor = LAMP_RED; end
    endcase
    return lp;
  endfunction

endpackage

// File: rtl/tlc_timer.sv
module tlc_timer #(
  parameter int SHORT_CYCLES = 16,
  parameter int LONG_CYCLES  = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic sel_long,
  output logic tmo
);
  localparam int MAXC = (LONG_CYCLES > SHORT_CYCLES) ? LONG_CYCLES : SHORT_CYCLES;
  localparam int CW   = (MAXC > 1) ? $clog2(MAXC) : 1;
  localparam logic [CW-1:0] SHORT_LD = CW'(SHORT_CYCLES - 1);
  localparam logic [CW-1:0] LONG_LD  = CW'(LONG_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;

  assign tmo = busy_q && (cnt_q == '0);

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = sel_long ? LONG_LD : SHORT_LD;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  AST_TMO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tmo && !start |=> !tmo); // R5

endmodule

// File: rtl/tlc_seq.sv
module tlc_seq
  import tlc_pkg::*;
#(
  parameter int SHORT_CYCLES = 16
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   car_present,
  input  logic   car_passed,
  input  logic   tmo,
  output phase_t ph_q,
  output phase_t ph_d,
  output logic   start,
  output logic   sel_long
);

  always_comb begin
    ph_d = ph_q;
    case (ph_q)
      PH_MAJ_GO:   if (car_present)       ph_d = PH_MAJ_WARN;
      PH_MAJ_WARN: if (tmo)               ph_d = PH_MIN_GO;
      PH_MIN_GO:   if (tmo || car_passed) ph_d = PH_MIN_WARN;
      PH_MIN_WARN: if (tmo)               ph_d = PH_MAJ_HOLD;
      PH_MAJ_HOLD: if (tmo)               ph_d = PH_MAJ_GO;
      default:                            ph_d = PH_MAJ_GO;
    endcase
  end

  // every phase entry except major go reloads the timer
  assign start    = (ph_d != ph_q) && (ph_d != PH_MAJ_GO);
  assign sel_long = (ph_d == PH_MIN_GO) || (ph_d == PH_MAJ_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_MAJ_GO;
    else        ph_q <= ph_d;
  end

  AST_MAJ_GO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q == PH_MAJ_GO && !car_present |=> ph_q == PH_MAJ_GO); // R2
  AST_MAJ_GO_LEAVE: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q == PH_MAJ_GO && car_present |=> ph_q == PH_MAJ_WARN); // R2
  AST_EARLY_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q == PH_MIN_GO && car_passed |=> ph_q == PH_MIN_WARN && (SHORT_CYCLES == 1 || !tmo)); // R5
  AST_HOLD_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q == PH_MAJ_HOLD && !tmo |=> ph_q == PH_MAJ_HOLD); // R7
  AST_WARN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q == PH_MAJ_WARN |=> ph_q == PH_MAJ_WARN || ph_q == PH_MIN_GO); // R8

endmodule

// File: rtl/tlc_lamps.sv
module tlc_lamps
  import tlc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  phase_t     ph_d,
  output logic [2:0] major_lamp,
  output logic [2:0] minor_lamp
);
  lamp_pair_t lp_d, lp_q;

  assign lp_d = phase_lamps(ph_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lp_q.major <= LAMP_GRN;
      lp_q.minor <= LAMP_RED;
    end else begin
      lp_q <= lp_d;
    end
  end

  assign major_lamp = lp_q.major;
  assign minor_lamp = lp_q.minor;

  AST_ONE_RED: assert property (@(posedge clk) disable iff (!rst_n)
    major_lamp[2] || minor_lamp[2]); // R9
  AST_NO_DUAL_GREEN: assert property (@(posedge clk) disable iff (!rst_n)
    !(major_lamp[0] && minor_lamp[0])); // R9

endmodule

// File: rtl/tlc_crossing.sv
module tlc_crossing
  import tlc_pkg::*;
#(
  parameter int SHORT_CYCLES = 16,
  parameter int LONG_CYCLES  = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       car_present,
  input  logic       car_passed,
  output logic [2:0] major_lamp,
  output logic [2:0] minor_lamp
);
  phase_t ph_q, ph_d;
  logic   start, sel_long, tmo;

  tlc_timer #(.SHORT_CYCLES(SHORT_CYCLES), .LONG_CYCLES(LONG_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .sel_long(sel_long), .tmo(tmo));

  tlc_seq #(.SHORT_CYCLES(SHORT_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .car_present(car_present), .car_passed(car_passed),
    .tmo(tmo), .ph_q(ph_q), .ph_d(ph_d), .start(start), .sel_long(sel_long));

  tlc_lamps u_lamps (
    .clk(clk), .rst_n(rst_n), .ph_d(ph_d),
    .major_lamp(major_lamp), .minor_lamp(minor_lamp));

  AST_R1_RESET_GO: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q == PH_MAJ_GO |-> major_lamp == LAMP_GRN && minor_lamp == LAMP_RED); // R1

endmodule

// File: tb/sim_tlc_crossing.sv
`timescale 1ns/1ps
module sim_tlc_crossing;
  localparam int SH = 3;
  localparam int LG = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic car_present = 1'b0;
  logic car_passed = 1'b0;
  logic [2:0] major_lamp, minor_lamp;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  always #5 clk = ~clk;

  tlc_crossing #(.SHORT_CYCLES(SH), .LONG_CYCLES(LG)) u0 (
    .clk(clk), .rst_n(rst_n), .car_present(car_present), .car_passed(car_passed),
    .major_lamp(major_lamp), .minor_lamp(minor_lamp));

  task automatic check(input string req, input logic [2:0] emaj, input logic [2:0] emin);
    n_tests++;
    if (major_lamp !== emaj || minor_lamp !== emin) begin
      n_fail++;
      $display("FAIL %s cycle %0d: major=%b minor=%b expected major=%b minor=%b",
               req, cyc, major_lamp, minor_lamp, emaj, emin);
    end
    n_tests++;
    if (!(major_lamp[2] || minor_lamp[2]) || (major_lamp[0] && minor_lamp[0])) begin
      n_fail++;
      $display("FAIL R9 cycle %0d: major=%b minor=%b expected a red and no dual green",
               cyc, major_lamp, minor_lamp);
    end
  endtask

  // one phase of len cycles; sensor pulses at given cycle indices (-1 = none)
  task automatic phase(input string req, input logic [2:0] emaj, input logic [2:0] emin,
                       input int len, input int ip, input int iq);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      car_present = (i == ip);
      car_passed  = (i == iq);
      check(req, emaj, emin);
    end
  endtask

  task automatic full_cycle(input int idle, input int k);
    int d2;
    d2 = (k < 0) ? LG : k + 1;
    // major go: car_passed noise early (R8), request on last cycle (R2)
    phase("R2", 3'b001, 3'b100, idle + 1, idle, (idle > 0) ? 0 : -1);
    // major warning: stray sensor pulses ignored (R3, R8)
    phase("R3", 3'b010, 3'b110, SH, 0, SH - 1);
    // minor go: early exit at k (R4, R5)
    phase((k < 0) ? "R4" : "R5", 3'b100, 3'b001, d2, 0, k);
    // minor warning full length after early exit (R5, R6)
    phase("R6", 3'b110, 3'b010, SH, 0, 0);
    // major hold ignores both sensors (R7, R8)
    phase("R7", 3'b001, 3'b100, LG, 1, LG - 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 3'b001, 3'b100);
    rst_n = 1'b1;
    for (int idle = 0; idle < 3; idle++) begin
      full_cycle(idle, -1);
      for (int k = 0; k < LG; k++) full_cycle(idle, k);
    end
    // reset in the middle of minor go returns to major go (R1)
    phase("R2", 3'b001, 3'b100, 1, 0, -1);
    phase("R3", 3'b010, 3'b110, SH, -1, -1);
    phase("R4", 3'b100, 3'b001, 2, -1, -1);
    @(negedge clk);
    car_present = 1'b0; car_passed = 1'b0;
    rst_n = 1'b0;
    #1;
    check("R1", 3'b001, 3'b100);
    @(negedge clk);
    rst_n = 1'b1;
    phase("R1", 3'b001, 3'b100, 4, -1, -1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: cycle %0d expected completion", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule